// File: doc/BRIEF.md
# Priority Service-Class Output Scheduler

This block is the output-port scheduler of a mesh router that offers four service classes. Each class presents at most one flit at a time through its own valid/ready pair, together with a two-bit flit kind. In every cycle the scheduler grants the output link to one class, and the granted flit leaves on a registered output port. The output port carries a two-bit class tag, so the next router can steer the flit into the matching buffer.

The grant follows strict class priority. Class 0 carries urgent signaling, class 1 real-time streams, class 2 read/write transactions and class 3 block transfers. A class is eligible only while it holds at least one credit toward its downstream buffer. Each class keeps its own credit counter, which the downstream router replenishes with one-cycle return pulses. Packets travel wormhole style on a per-class basis. A higher class may cut into a lower-class packet flit by flit, and the interrupted packet continues from where it stopped once the higher class goes quiet.

Top module: `qos_out_sched`

## Requirements
- R1: After reset, `outValid` is 0 and every class holds `CREDIT_DEPTH` credits. With no return pulses, a class can therefore send exactly `CREDIT_DEPTH` flits.
- R2: `inReady` is zero or one-hot. It is high only for the lowest-numbered class that has `inValid` high and a non-zero credit count.
- R3: A flit accepted (`inValid` and `inReady` both high) at a clock edge appears on `outValid`/`outData`/`outKind` right after that edge. In a cycle with no acceptance, `outValid` is 0 after the next edge.
- R4: `outClass` carries the index of the class whose flit is on the output: 0 signaling, 1 real-time, 2 read/write, 3 block transfer.
- R5: A class whose credit count is zero is never granted, whatever its priority.
- R6: A credit return pulse raises that class's count by one at the next edge. A send and a return for the same class in the same cycle leave the count unchanged. The count never exceeds `CREDIT_DEPTH`.
- R7: When a higher class is requesting but has no credit, the highest lower class that has both a flit and a credit is granted instead.
- R8: A higher class that starts requesting while a lower-class packet is partly sent takes the link on the next grant. The lower packet's remaining flits follow, in order, once the higher class stops requesting.
- R9: The flit kind is encoded as 2'b00 body (a non-last flit), 2'b01 end of packet, and 2'b10 single-flit packet. An end or single-flit kind closes the class's open packet. A single-flit packet never leaves a class while that class's packet is still open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 4 | Per-class flit present |
| inReady | output | 4 | Per-class grant; flit taken at the edge when valid is high |
| inData | input | 4*FLIT_W | Per-class flit payload, class c in bits [c*FLIT_W +: FLIT_W] |
| inKind | input | 8 | Per-class flit kind, class c in bits [c*2 +: 2] |
| creditRet | input | 4 | Per-class one-cycle credit return pulse from downstream |
| outValid | output | 1 | Output flit valid |
| outData | output | FLIT_W | Output flit payload |
| outKind | output | 2 | Output flit kind |
| outClass | output | 2 | Service class tag of the output flit |

## Verification
`inReady` is combinational on the current inputs and the registered credit counts. The bench therefore compares it with the value from its own credit model 1 ns after driving the inputs, in the same cycle. A credit spent or returned changes eligibility from the following cycle onward, and the bench model applies that update only after its check for the current cycle. Each accepted flit is pushed into a scoreboard queue. The monitor pops one entry per clock 1 ns after each rising edge, which is one register after acceptance, and compares valid, payload, kind and class tag there.

// File: rtl/qos_sched_pkg.sv
package qos_sched_pkg;
  localparam int NUM_CLS = 4;
  localparam int CLS_W = $clog2(NUM_CLS);
  localparam int KIND_W = 2;

  localparam logic [KIND_W-1:0] KIND_BODY = 2'b00;
  localparam logic [KIND_W-1:0] KIND_END  = 2'b01;
  localparam logic [KIND_W-1:0] KIND_SOLO = 2'b10;

  typedef struct packed {
    logic             fire;
    logic [CLS_W-1:0] sel;
  } schedStrobe_t;
endpackage

// File: rtl/class_credit.sv
module class_credit #(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             take,
  input  logic             give,
  output logic [CNT_W-1:0] level,
  output logic             hasCredit
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      level <= CNT_W'(DEPTH);
    end else begin
      case ({take, give})
        2'b10:   level <= level - 1'b1;
        2'b01:   level <= level + 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign hasCredit = (level != '0);
endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import qos_sched_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CLS-1:0]       inValid,
  input  logic [NUM_CLS-1:0]       creditRet,
  output logic [NUM_CLS-1:0]       inReady,
  output schedStrobe_t             strb,
  output logic [NUM_CLS*CNT_W-1:0] creditLvl
);
  logic [NUM_CLS-1:0] hasCredit;
  logic [NUM_CLS-1:0] eligible;
  logic [CLS_W-1:0]   pick;
  logic               found;

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_credit
    class_credit #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_credit (
      .clk      (clk),
      .rstN     (rstN),
      .take     (inReady[g] & inValid[g]),
      .give     (creditRet[g]),
      .level    (creditLvl[g*CNT_W +: CNT_W]),
      .hasCredit(hasCredit[g])
    );
  end

  assign eligible = inValid & hasCredit;

  // lowest index is highest priority; classes without credit drop out
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int c = 0; c < NUM_CLS; c++) begin
      if (!found && eligible[c]) begin
        pick  = CLS_W'(c);
        found = 1'b1;
      end
    end
  end

  assign inReady   = found ? (NUM_CLS'(1) << pick) : '0;
  assign strb.fire = found;
  assign strb.sel  = pick;
endmodule

// File: rtl/sched_dp.sv
module sched_dp
  import qos_sched_pkg::*;
#(
  parameter int FLIT_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  schedStrobe_t              strb,
  input  logic [NUM_CLS*FLIT_W-1:0] inData,
  input  logic [NUM_CLS*KIND_W-1:0] inKind,
  output logic                      outValid,
  output logic [FLIT_W-1:0]         outData,
  output logic [KIND_W-1:0]         outKind,
  output logic [CLS_W-1:0]          outClass
);
  logic [FLIT_W-1:0] flitArr [NUM_CLS];
  logic [KIND_W-1:0] kindArr [NUM_CLS];

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_split
    assign flitArr[g] = inData[g*FLIT_W +: FLIT_W];
    assign kindArr[g] = inKind[g*KIND_W +: KIND_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outKind  <= '0;
      outClass <= '0;
    end else begin
      outValid <= strb.fire;
      if (strb.fire) begin
        outData  <= flitArr[strb.sel];
        outKind  <= kindArr[strb.sel];
        outClass <= strb.sel;
      end
    end
  end
endmodule

// File: rtl/qos_out_sched.sv
module qos_out_sched
  import qos_sched_pkg::*;
#(
  parameter int FLIT_W       = 32,
  parameter int CREDIT_DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_CLS-1:0]        inValid,
  output logic [NUM_CLS-1:0]        inReady,
  input  logic [NUM_CLS*FLIT_W-1:0] inData,
  input  logic [NUM_CLS*KIND_W-1:0] inKind,
  input  logic [NUM_CLS-1:0]        creditRet,
  output logic                      outValid,
  output logic [FLIT_W-1:0]         outData,
  output logic [KIND_W-1:0]         outKind,
  output logic [CLS_W-1:0]          outClass
);
  localparam int CNT_W = $clog2(CREDIT_DEPTH + 1);

  schedStrobe_t             strb;
  logic [NUM_CLS*CNT_W-1:0] creditLvl;

  sched_ctrl #(.DEPTH(CREDIT_DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .creditRet(creditRet),
    .inReady  (inReady),
    .strb     (strb),
    .creditLvl(creditLvl)
  );

  sched_dp #(.FLIT_W(FLIT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .inData  (inData),
    .inKind  (inKind),
    .outValid(outValid),
    .outData (outData),
    .outKind (outKind),
    .outClass(outClass)
  );
endmodule

// File: rtl/qos_out_sched_chk.sv
module qos_out_sched_chk
  import qos_sched_pkg::*;
#(
  parameter int FLIT_W = 32,
  parameter int CNT_W  = 3,
  parameter int DEPTH  = 4
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_CLS-1:0]        inValid,
  input logic [NUM_CLS-1:0]        inReady,
  input logic [NUM_CLS*FLIT_W-1:0] inData,
  input logic [NUM_CLS-1:0]        creditRet,
  input logic                      outValid,
  input logic [FLIT_W-1:0]         outData,
  input logic [KIND_W-1:0]         outKind,
  input logic [CLS_W-1:0]          outClass,
  input logic [NUM_CLS*CNT_W-1:0]  creditLvl
);
  logic [NUM_CLS-1:0] accept;
  logic [CLS_W-1:0]   accIdx;
  logic [FLIT_W-1:0]  accData;
  logic [NUM_CLS-1:0] openFlag;
  logic [NUM_CLS-1:0] canGo;

  assign accept = inValid & inReady;

  always_comb begin
    accIdx  = '0;
    accData = '0;
    for (int c = 0; c < NUM_CLS; c++) begin
      canGo[c] = inValid[c] && (creditLvl[c*CNT_W +: CNT_W] != '0);
      if (accept[c]) begin
        accIdx  = CLS_W'(c);
        accData = inData[c*FLIT_W +: FLIT_W];
      end
    end
  end

  // packet-open tracking seen from the output link
  always_ff @(posedge clk) begin
    if (!rstN) openFlag <= '0;
    else if (outValid) openFlag[outClass] <= (outKind == KIND_BODY);
  end

  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(inReady));

  a_r2_ready_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    (inReady & ~inValid) == '0);

  a_r3_latency: assert property (@(posedge clk) disable iff (!rstN)
    (|accept) |=> (outValid && outClass == $past(accIdx) && outData == $past(accData)));

  a_r3_idle: assert property (@(posedge clk) disable iff (!rstN)
    !(|accept) |=> !outValid);

  a_r9_no_solo_while_open: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && openFlag[outClass]) |-> (outKind != KIND_SOLO));

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
    a_r5_no_send_without_credit: assert property (@(posedge clk) disable iff (!rstN)
      accept[g] |-> (creditLvl[g*CNT_W +: CNT_W] != '0));

    a_r6_credit_bound: assert property (@(posedge clk) disable iff (!rstN)
      creditLvl[g*CNT_W +: CNT_W] <= CNT_W'(DEPTH));

    if (g > 0) begin : g_hi
      a_r7_no_skip_eligible: assert property (@(posedge clk) disable iff (!rstN)
        accept[g] |-> (canGo[g-1:0] == '0));
    end
  end
endmodule

bind qos_out_sched qos_out_sched_chk #(
  .FLIT_W(FLIT_W),
  .CNT_W (CNT_W),
  .DEPTH (CREDIT_DEPTH)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .inData   (inData),
  .creditRet(creditRet),
  .outValid (outValid),
  .outData  (outData),
  .outKind  (outKind),
  .outClass (outClass),
  .creditLvl(creditLvl)
);

// File: tb/tb_qos_out_sched.sv
`timescale 1ns/1ps
module tb_qos_out_sched;
  localparam int FW = 32;
  localparam int NC = 4;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NC-1:0] inValid = '0;
  logic [NC-1:0] inReady;
  logic [NC*FW-1:0] inData = '0;
  logic [NC*2-1:0]  inKind = '0;
  logic [NC-1:0] creditRet = '0;
  logic          outValid;
  logic [FW-1:0] outData;
  logic [1:0]    outKind;
  logic [1:0]    outClass;

  qos_out_sched #(.FLIT_W(FW), .CREDIT_DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inKind(inKind), .creditRet(creditRet),
    .outValid(outValid), .outData(outData), .outKind(outKind), .outClass(outClass)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    bit          v;
    logic [1:0]  cls;
    logic [FW-1:0] data;
    logic [1:0]  kind;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0;
  int bad = 0;
  bit monOn = 0;
  bit finished = 0;

  // bench model state
  int cr[NC];
  int remain[NC];
  int pktLen[NC];
  int seq[NC];
  bit en[NC];
  bit autoRet = 0;
  logic [NC-1:0] lastSent = '0;

  function automatic logic [1:0] kindOf(int c);
    int k = pktLen[c] - remain[c];
    if (pktLen[c] == 1) return 2'b10;      // single-flit packet
    if (k == pktLen[c] - 1) return 2'b01;  // end of packet
    return 2'b00;                          // body
  endfunction

  task automatic setPkt(int c, int len);
    remain[c] = len;
    pktLen[c] = len;
    en[c] = 1;
  endtask

  task automatic step(logic [NC-1:0] retMask, string tag);
    logic [NC-1:0] ret;
    logic [NC-1:0] readyExp;
    int win;
    expItem_t e;
    @(negedge clk);
    ret = retMask | (autoRet ? lastSent : '0);
    for (int c = 0; c < NC; c++) begin
      inValid[c] = en[c] && remain[c] > 0;
      inData[c*FW +: FW] = (32'(c) << 24) | 32'(seq[c]);
      inKind[c*2 +: 2] = kindOf(c);
    end
    creditRet = ret;
    #1;
    win = -1;
    for (int c = 0; c < NC; c++)
      if (win < 0 && inValid[c] && cr[c] > 0) win = c;
    readyExp = (win >= 0) ? (NC'(1) << win) : '0;
    total++;
    if (inReady !== readyExp) begin
      bad++;
      $display("FAIL %s grant: inReady=%b expected=%b", tag, inReady, readyExp);
    end
    e.v = (win >= 0);
    e.cls = (win >= 0) ? 2'(win) : 2'd0;
    e.data = (win >= 0) ? inData[win*FW +: FW] : '0;
    e.kind = (win >= 0) ? inKind[win*2 +: 2] : 2'd0;
    expQ.push_back(e);
    lastSent = '0;
    if (win >= 0) begin
      cr[win]--;
      remain[win]--;
      seq[win]++;
      lastSent[win] = 1'b1;
    end
    for (int c = 0; c < NC; c++) if (ret[c]) cr[c]++;
  endtask

  task automatic drain(int n);
    for (int c = 0; c < NC; c++) en[c] = 0;
    autoRet = 1;
    for (int i = 0; i < n; i++) step('0, "R3 drain");
  endtask

  // monitor: one entry per cycle, sampled one register after acceptance
  always @(posedge clk) begin
    if (monOn) begin
      expItem_t e;
      #1;
      if (expQ.size() > 0) e = expQ.pop_front();
      else begin e.v = 0; e.cls = 0; e.data = 0; e.kind = 0; end
      total++;
      if (outValid !== e.v) begin
        bad++;
        $display("FAIL R3 outValid=%b expected=%b", outValid, e.v);
      end else if (e.v && (outClass !== e.cls || outData !== e.data || outKind !== e.kind)) begin
        bad++;
        $display("FAIL R3 R4 R9 out cls=%0d data=%h kind=%b expected cls=%0d data=%h kind=%b",
                 outClass, outData, outKind, e.cls, e.data, e.kind);
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    for (int c = 0; c < NC; c++) begin
      cr[c] = DEPTH; remain[c] = 0; pktLen[c] = 1; seq[c] = 0; en[c] = 0;
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    monOn = 1;
    #1;
    total++;
    if (outValid !== 1'b0 || inReady !== '0) begin
      bad++;
      $display("FAIL R1 reset state outValid=%b inReady=%b expected 0 and 0000", outValid, inReady);
    end

    // R1 full credit, R3 latency, R9 kinds: four flits with no returns, fifth attempt stalls
    setPkt(2, 5);
    for (int i = 0; i < 5; i++) step('0, "R1 R5 class2 burst");
    // R6 return pulses: first restores one credit, remaining flit goes next cycle
    step(4'b0100, "R6 return");
    step(4'b0100, "R6 send+return");
    step(4'b0100, "R6 return");
    step(4'b0100, "R6 return");
    drain(3);

    // R2 strict priority with all four classes holding single-flit packets
    for (int c = 0; c < NC; c++) setPkt(c, 1);
    autoRet = 1;
    for (int i = 0; i < 4; i++) step('0, "R2 priority order");
    drain(3);

    // R8 pre-emption: class 3 packet interrupted by class 0, then resumes
    autoRet = 1;
    setPkt(3, 6);
    step('0, "R8 lower start");
    step('0, "R8 lower body");
    setPkt(0, 2);
    step('0, "R8 higher preempts");
    step('0, "R8 higher end");
    for (int i = 0; i < 4; i++) step('0, "R8 lower resumes");
    drain(3);

    // R7 fallback: class 1 out of credit, class 2 takes the link
    autoRet = 0;
    setPkt(1, 4);
    for (int i = 0; i < 4; i++) step('0, "R5 drain class1");
    setPkt(1, 2);
    setPkt(2, 2);
    step('0, "R7 fallback to class2");
    step('0, "R7 fallback to class2");
    step(4'b0010, "R7 R6 class1 credit back");
    step(4'b0010, "R6 send and return same cycle");
    step(4'b0010, "R6 send and return same cycle");
    step(4'b0110, "R6 return");
    step(4'b0110, "R6 return");
    step(4'b0010, "R6 return");
    drain(4);

    // R2 mixed: class 1 and 3 packets interleave by priority
    autoRet = 1;
    setPkt(3, 3);
    setPkt(1, 2);
    for (int i = 0; i < 5; i++) step('0, "R2 R8 mixed");
    drain(4);

    monOn = 0;
    finish();
  end
endmodule